// File: doc/BRIEF.md
# Function Event Notification Queue

This block keeps pending event records for a group of I/O functions in a single first-in first-out queue. It hands them to a consumer one at a time. A producer port writes either an error record or an availability record. Each record holds a function identifier, a function handle and a 16-bit event code. An error record also holds a 64-bit fault address and a 32-bit qualifier word. Every record that is stored raises a one-cycle notification pulse for the channel subsystem.

A built-in hot-plug sequencer writes the availability records for plug and unplug requests in a fixed order:

- **Plug:** two events.
- **Unplug of a configured function:** two events, plus a pulse that marks the function unconfigured.
- **Unplug of a function that is not configured:** one event.

The consumer watches the "have event" output and strobes pop. One cycle later a registered response appears. It carries a type code, a fixed length and the head record, packed big-endian into a 176-bit payload. The payload layout depends on the record's type.

The queue depth is a parameter. A write to a full queue is lost and sets a sticky overflow flag.

Top module: `fn_event_queue`

## Requirements
- R1: A pop on a non-empty queue removes and returns the oldest stored record; records come out in the order they were stored.
- R2: `have_event_o` is 1 exactly when at least one record is stored; it reflects each push or pop from the cycle after the clock edge that performs it.
- R3: A popped error record gives `rsp_type_o` = 1 and `rsp_data_o` = {code[175:160], fid[159:128], fh[127:96], fault address[95:32], qualifier[31:0]}.
- R4: A popped availability record gives `rsp_type_o` = 2 and `rsp_data_o` = {code[175:160], fid[159:128], fh[127:96]}, with bits [95:0] zero.
- R5: A pop on an empty queue gives `rsp_type_o` = 0 ("no event") and an all-zero payload, and leaves the queue unchanged.
- R6: Every pop produces `rsp_valid_o` = 1 in the cycle after the pop edge, with `rsp_len_o` = 26 (4 header bytes plus 22 payload bytes).
- R7: `notify_o` pulses for one cycle after each edge at which a record is stored, and stays low when no record is stored.
- R8: A write to a full queue is dropped and sets `ovf_o`, which stays 1 until reset. A write in the same cycle as a pop of a full queue is stored.
- R9: A plug request stores two availability records in consecutive cycles: code 0x0301 (reserved to standby), then code 0x0302 (standby to configured), both with the request's fid and fh.
- R10: An unplug request with `hp_cfg_i` = 1 stores code 0x0303 (configured to standby) and pulses `unconfig_o` in the next cycle, then stores code 0x0304 (standby to reserved). With `hp_cfg_i` = 0, it stores only 0x0304.
- R11: A producer push in a cycle where the sequencer writes is dropped. Plug and unplug requests that arrive while the sequencer's second record is still pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Producer write strobe |
| push_err_i | input | 1 | 1 = error record, 0 = availability record |
| push_fid_i | input | 32 | Function identifier |
| push_fh_i | input | 32 | Function handle |
| push_code_i | input | 16 | Event code |
| push_addr_i | input | 64 | Fault address (error records only) |
| push_qual_i | input | 32 | Qualifier word (error records only) |
| plug_i | input | 1 | Hot-plug request |
| unplug_i | input | 1 | Hot-unplug request |
| hp_cfg_i | input | 1 | Function being unplugged is configured |
| hp_fid_i | input | 32 | Function identifier for plug/unplug |
| hp_fh_i | input | 32 | Function handle for plug/unplug |
| unconfig_o | output | 1 | Pulse: the unplugged function is now unconfigured |
| notify_o | output | 1 | Channel-report pulse after each stored record |
| pop_i | input | 1 | Consumer pop strobe |
| have_event_o | output | 1 | Queue not empty |
| rsp_valid_o | output | 1 | Response valid (cycle after pop) |
| rsp_type_o | output | 8 | 0 none, 1 error, 2 availability |
| rsp_len_o | output | 16 | Response length in bytes |
| rsp_data_o | output | 176 | Big-endian packed record payload |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench sweeps the fill level of a four-deep queue from empty to full with alternating record kinds. It then pops one more than it pushed, so the empty pop is exercised at every level.

Each corner case catches a specific defect:

- **Pointer wrap or count error:** record order goes wrong or `have_event_o` drifts.
- **Wrong format select:** an error payload appears under type 2, or an availability payload keeps non-zero tail bits.
- **Full-queue handling:** pushing into a full queue, alone and together with a pop, catches a design that overwrites the head, that refuses the write which a simultaneous pop makes room for, or whose overflow flag does not stick.
- **Hot-plug sequencing:** plug and unplug runs, with a colliding producer push and a late request, expose swapped event order, a missing unconfigure pulse, or a sequencer that lets a second write in.

// File: rtl/fnq_pkg.sv
package fnq_pkg;
    localparam int FID_W     = 32;
    localparam int FH_W      = 32;
    localparam int CODE_W    = 16;
    localparam int ADDR_W    = 64;
    localparam int QUAL_W    = 32;
    localparam int PAYLOAD_W = CODE_W + FID_W + FH_W + ADDR_W + QUAL_W;
    localparam int TAIL_W    = ADDR_W + QUAL_W;
    localparam int HDR_BYTES = 4;
    localparam int RSP_BYTES = HDR_BYTES + PAYLOAD_W / 8;

    typedef enum logic [7:0] {
        RSP_NONE  = 8'd0,
        RSP_ERR   = 8'd1,
        RSP_AVAIL = 8'd2
    } rsp_type_e;

    // hot-plug transition codes
    localparam logic [CODE_W-1:0] HP_RSV_TO_STBY = 16'h0301;
    localparam logic [CODE_W-1:0] HP_STBY_TO_CFG = 16'h0302;
    localparam logic [CODE_W-1:0] HP_CFG_TO_STBY = 16'h0303;
    localparam logic [CODE_W-1:0] HP_STBY_TO_RSV = 16'h0304;

    typedef struct packed {
        logic              is_err;
        logic [CODE_W-1:0] code;
        logic [FID_W-1:0]  fid;
        logic [FH_W-1:0]   fh;
        logic [ADDR_W-1:0] addr;
        logic [QUAL_W-1:0] qual;
    } evt_rec_t;
endpackage

// File: rtl/fnq_hp_seq.sv
module fnq_hp_seq
    import fnq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              plug_i,
    input  logic              unplug_i,
    input  logic              cfg_i,
    input  logic [FID_W-1:0]  fid_i,
    input  logic [FH_W-1:0]   fh_i,
    output logic              wr_o,
    output logic [CODE_W-1:0] code_o,
    output logic [FID_W-1:0]  fid_o,
    output logic [FH_W-1:0]   fh_o,
    output logic              unconfig_o
);
    typedef struct packed {
        logic              pend;
        logic [CODE_W-1:0] code;
        logic [FID_W-1:0]  fid;
        logic [FH_W-1:0]   fh;
        logic              unconfig;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.unconfig = 1'b0;
        wr_o          = 1'b0;
        code_o        = '0;
        fid_o         = fid_i;
        fh_o          = fh_i;
        if (st_q.pend) begin
            // second record of a pair; new requests are ignored here
            wr_o      = 1'b1;
            code_o    = st_q.code;
            fid_o     = st_q.fid;
            fh_o      = st_q.fh;
            st_d.pend = 1'b0;
        end else if (plug_i) begin
            wr_o      = 1'b1;
            code_o    = HP_RSV_TO_STBY;
            st_d.pend = 1'b1;
            st_d.code = HP_STBY_TO_CFG;
            st_d.fid  = fid_i;
            st_d.fh   = fh_i;
        end else if (unplug_i) begin
            wr_o = 1'b1;
            if (cfg_i) begin
                code_o        = HP_CFG_TO_STBY;
                st_d.unconfig = 1'b1;
                st_d.pend     = 1'b1;
                st_d.code     = HP_STBY_TO_RSV;
                st_d.fid      = fid_i;
                st_d.fh       = fh_i;
            end else begin
                code_o = HP_STBY_TO_RSV;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unconfig_o = st_q.unconfig;
endmodule

// File: rtl/fnq_store.sv
module fnq_store
    import fnq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_i,
    input  evt_rec_t wr_rec_i,
    input  logic     rd_i,
    output evt_rec_t head_o,
    output logic     empty_o,
    output logic     accept_o,
    output logic     ovf_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        evt_rec_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]     wp;
        logic [PTR_W-1:0]     rp;
        logic [CNT_W-1:0]     cnt;
        logic                 ovf;
    } store_st_t;

    store_st_t st_d, st_q;
    logic      rd_hit;
    logic      full;

    always_comb begin
        st_d     = st_q;
        rd_hit   = rd_i && (st_q.cnt != '0);
        full     = (st_q.cnt == CNT_W'(DEPTH));
        accept_o = wr_i && (!full || rd_hit);
        if (wr_i && !accept_o) st_d.ovf = 1'b1;
        if (accept_o) begin
            st_d.mem[st_q.wp] = wr_rec_i;
            st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        end
        if (rd_hit) st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        case ({accept_o, rd_hit})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rp];
    assign empty_o = (st_q.cnt == '0);
    assign ovf_o   = st_q.ovf;
endmodule

// File: rtl/fnq_fmt.sv
module fnq_fmt
    import fnq_pkg::*;
(
    input  logic                 valid_i,
    input  evt_rec_t             rec_i,
    output logic [7:0]           type_o,
    output logic [PAYLOAD_W-1:0] data_o
);
    always_comb begin
        if (!valid_i) begin
            type_o = RSP_NONE;
            data_o = '0;
        end else if (rec_i.is_err) begin
            type_o = RSP_ERR;
            data_o = {rec_i.code, rec_i.fid, rec_i.fh, rec_i.addr, rec_i.qual};
        end else begin
            type_o = RSP_AVAIL;
            data_o = {rec_i.code, rec_i.fid, rec_i.fh, {TAIL_W{1'b0}}};
        end
    end
endmodule

// File: rtl/fn_event_queue.sv
module fn_event_queue
    import fnq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_i,
    input  logic                 push_err_i,
    input  logic [31:0]          push_fid_i,
    input  logic [31:0]          push_fh_i,
    input  logic [15:0]          push_code_i,
    input  logic [63:0]          push_addr_i,
    input  logic [31:0]          push_qual_i,
    input  logic                 plug_i,
    input  logic                 unplug_i,
    input  logic                 hp_cfg_i,
    input  logic [31:0]          hp_fid_i,
    input  logic [31:0]          hp_fh_i,
    output logic                 unconfig_o,
    output logic                 notify_o,
    input  logic                 pop_i,
    output logic                 have_event_o,
    output logic                 rsp_valid_o,
    output logic [7:0]           rsp_type_o,
    output logic [15:0]          rsp_len_o,
    output logic [175:0]         rsp_data_o,
    output logic                 ovf_o
);
    typedef struct packed {
        logic                 rsp_valid;
        logic [7:0]           rsp_type;
        logic [PAYLOAD_W-1:0] rsp_data;
        logic                 notify;
    } top_st_t;

    top_st_t              st_d, st_q;
    logic                 seq_wr;
    logic [CODE_W-1:0]    seq_code;
    logic [FID_W-1:0]     seq_fid;
    logic [FH_W-1:0]      seq_fh;
    evt_rec_t             wr_rec;
    logic                 wr_en;
    evt_rec_t             head;
    logic                 empty;
    logic                 accept;
    logic [7:0]           fmt_type;
    logic [PAYLOAD_W-1:0] fmt_data;

    fnq_hp_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .plug_i     (plug_i),
        .unplug_i   (unplug_i),
        .cfg_i      (hp_cfg_i),
        .fid_i      (hp_fid_i),
        .fh_i       (hp_fh_i),
        .wr_o       (seq_wr),
        .code_o     (seq_code),
        .fid_o      (seq_fid),
        .fh_o       (seq_fh),
        .unconfig_o (unconfig_o)
    );

    // sequencer owns the write port when it writes; producer push is lost
    always_comb begin
        wr_en = seq_wr || push_i;
        if (seq_wr) begin
            wr_rec = '{is_err: 1'b0, code: seq_code, fid: seq_fid,
                       fh: seq_fh, addr: '0, qual: '0};
        end else begin
            wr_rec = '{is_err: push_err_i, code: push_code_i, fid: push_fid_i,
                       fh: push_fh_i, addr: push_addr_i, qual: push_qual_i};
        end
    end

    fnq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_en),
        .wr_rec_i (wr_rec),
        .rd_i     (pop_i),
        .head_o   (head),
        .empty_o  (empty),
        .accept_o (accept),
        .ovf_o    (ovf_o)
    );

    fnq_fmt u_fmt (
        .valid_i (!empty),
        .rec_i   (head),
        .type_o  (fmt_type),
        .data_o  (fmt_data)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = pop_i;
        st_d.notify    = accept;
        if (pop_i) begin
            st_d.rsp_type = fmt_type;
            st_d.rsp_data = fmt_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign notify_o     = st_q.notify;
    assign have_event_o = !empty;
    assign rsp_valid_o  = st_q.rsp_valid;
    assign rsp_type_o   = st_q.rsp_type;
    assign rsp_data_o   = st_q.rsp_data;
    assign rsp_len_o    = 16'(RSP_BYTES);
endmodule

// File: rtl/fn_event_queue_chk.sv
module fn_event_queue_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         pop_i,
    input logic         unplug_i,
    input logic         hp_cfg_i,
    input logic         have_event_o,
    input logic         notify_o,
    input logic         unconfig_o,
    input logic         rsp_valid_o,
    input logic [7:0]   rsp_type_o,
    input logic [15:0]  rsp_len_o,
    input logic [175:0] rsp_data_o,
    input logic         ovf_o
);
    p_pop_oldest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && have_event_o |=> rsp_valid_o && (rsp_type_o == 8'd1 || rsp_type_o == 8'd2));

    p_avail_tail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_type_o == 8'd2 |-> rsp_data_o[95:0] == '0);

    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !have_event_o |=> rsp_valid_o && rsp_type_o == 8'd0 && rsp_data_o == '0);

    p_rsp_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> rsp_len_o == 16'd26);

    p_notify_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        notify_o |-> have_event_o);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    p_unconfig_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unconfig_o |-> $past(unplug_i && hp_cfg_i));
endmodule

bind fn_event_queue fn_event_queue_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pop_i        (pop_i),
    .unplug_i     (unplug_i),
    .hp_cfg_i     (hp_cfg_i),
    .have_event_o (have_event_o),
    .notify_o     (notify_o),
    .unconfig_o   (unconfig_o),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_type_o   (rsp_type_o),
    .rsp_len_o    (rsp_len_o),
    .rsp_data_o   (rsp_data_o),
    .ovf_o        (ovf_o)
);

// File: tb/fn_event_queue_bench.sv
module fn_event_queue_bench;
    localparam int DEPTH = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_i = 1'b0, push_err_i = 1'b0;
    logic [31:0]  push_fid_i = '0, push_fh_i = '0, push_qual_i = '0;
    logic [15:0]  push_code_i = '0;
    logic [63:0]  push_addr_i = '0;
    logic         plug_i = 1'b0, unplug_i = 1'b0, hp_cfg_i = 1'b0;
    logic [31:0]  hp_fid_i = '0, hp_fh_i = '0;
    logic         pop_i = 1'b0;
    logic         unconfig_o, notify_o, have_event_o, rsp_valid_o, ovf_o;
    logic [7:0]   rsp_type_o;
    logic [15:0]  rsp_len_o;
    logic [175:0] rsp_data_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit           m_err[$];
    logic [175:0] m_dat[$];
    bit           exp_ovf = 1'b0;

    always #10 clk = ~clk;

    fn_event_queue #(.DEPTH(DEPTH)) u_fn_event_queue (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .push_err_i(push_err_i), .push_fid_i(push_fid_i),
        .push_fh_i(push_fh_i), .push_code_i(push_code_i), .push_addr_i(push_addr_i),
        .push_qual_i(push_qual_i), .plug_i(plug_i), .unplug_i(unplug_i),
        .hp_cfg_i(hp_cfg_i), .hp_fid_i(hp_fid_i), .hp_fh_i(hp_fh_i),
        .unconfig_o(unconfig_o), .notify_o(notify_o), .pop_i(pop_i),
        .have_event_o(have_event_o), .rsp_valid_o(rsp_valid_o),
        .rsp_type_o(rsp_type_o), .rsp_len_o(rsp_len_o), .rsp_data_o(rsp_data_o),
        .ovf_o(ovf_o)
    );

    task automatic chk(input string req, input logic [175:0] act, input logic [175:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [175:0] pack_rec(input bit err, input logic [15:0] code,
            input logic [31:0] fid, input logic [31:0] fh, input logic [63:0] addr,
            input logic [31:0] qual);
        if (err) return {code, fid, fh, addr, qual};
        return {code, fid, fh, 96'h0};
    endfunction

    task automatic do_push(input bit err, input logic [15:0] code, input logic [31:0] fid,
            input logic [31:0] fh, input logic [63:0] addr, input logic [31:0] qual);
        bit acc;
        acc = (m_dat.size() < DEPTH);
        @(negedge clk);
        push_i = 1'b1; push_err_i = err; push_code_i = code; push_fid_i = fid;
        push_fh_i = fh; push_addr_i = addr; push_qual_i = qual;
        @(posedge clk); #1;
        push_i = 1'b0;
        chk("R7 notify on push", notify_o, acc);
        if (acc) begin
            m_err.push_back(err);
            m_dat.push_back(pack_rec(err, code, fid, fh, addr, qual));
        end else begin
            exp_ovf = 1'b1;
        end
        chk("R8 overflow flag", ovf_o, exp_ovf);
        chk("R2 have_event after push", have_event_o, m_dat.size() != 0);
    endtask

    task automatic check_rsp();
        chk("R6 rsp_valid", rsp_valid_o, 1'b1);
        chk("R6 rsp_len", rsp_len_o, 16'd26);
        if (m_dat.size() == 0) begin
            chk("R5 empty pop type", rsp_type_o, 8'd0);
            chk("R5 empty pop data", rsp_data_o, '0);
        end else begin
            bit e;
            logic [175:0] d;
            e = m_err.pop_front();
            d = m_dat.pop_front();
            chk(e ? "R3 error type" : "R4 avail type", rsp_type_o, e ? 8'd1 : 8'd2);
            chk("R1 head record data", rsp_data_o, d);
        end
    endtask

    task automatic do_pop();
        @(negedge clk);
        pop_i = 1'b1;
        @(posedge clk); #1;
        pop_i = 1'b0;
        check_rsp();
        chk("R2 have_event after pop", have_event_o, m_dat.size() != 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R2 reset have_event", have_event_o, 1'b0);
        chk("R8 reset ovf", ovf_o, 1'b0);
        chk("R6 reset rsp_valid", rsp_valid_o, 1'b0);
        chk("R7 reset notify", notify_o, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // fill-level sweep, each followed by one extra pop of an empty queue (R5)
        for (int n = 0; n <= DEPTH; n++) begin
            for (int i = 0; i < n; i++)
                do_push(((i + n) % 2) == 0, 16'h0040 + 16'(i), 32'h100 * n + i,
                        32'h8000_0000 | (32'h10 * n + i), {32'hA5A5_0000 | n, 32'h1000 * i},
                        32'h11 * i + n);
            for (int i = 0; i <= n; i++) do_pop();
        end

        // full queue: overflow, then push together with pop (R8)
        for (int i = 0; i < DEPTH + 1; i++)
            do_push(i % 2 == 1, 16'h0700 + 16'(i), 32'h7000 + i, 32'h7700 + i,
                    64'hDEAD_0000_0000_0000 + i, 32'hC0 + i);
        @(negedge clk);
        push_i = 1'b1; pop_i = 1'b1; push_err_i = 1'b1; push_code_i = 16'h0999;
        push_fid_i = 32'h9; push_fh_i = 32'h99; push_addr_i = 64'h9999; push_qual_i = 32'h999;
        @(posedge clk); #1;
        push_i = 1'b0; pop_i = 1'b0;
        check_rsp();
        chk("R8 push with pop on full stored", notify_o, 1'b1);
        m_err.push_back(1'b1);
        m_dat.push_back(pack_rec(1'b1, 16'h0999, 32'h9, 32'h99, 64'h9999, 32'h999));
        for (int i = 0; i <= DEPTH; i++) do_pop();
        chk("R8 overflow sticky", ovf_o, 1'b1);

        // plug with a colliding producer push and a late unplug (R9, R11)
        @(negedge clk);
        plug_i = 1'b1; hp_fid_i = 32'h21; hp_fh_i = 32'h8000_0021;
        @(posedge clk); #1;
        plug_i = 1'b0;
        chk("R9 first plug record notify", notify_o, 1'b1);
        push_i = 1'b1; push_err_i = 1'b1; push_code_i = 16'hBAD0;
        unplug_i = 1'b1; hp_cfg_i = 1'b1;
        @(posedge clk); #1;
        push_i = 1'b0; unplug_i = 1'b0;
        chk("R9 second plug record notify", notify_o, 1'b1);
        @(posedge clk); #1;
        chk("R11 collided push and late unplug dropped", notify_o, 1'b0);
        chk("R11 late unplug no unconfig", unconfig_o, 1'b0);
        m_err.push_back(1'b0); m_dat.push_back(pack_rec(1'b0, 16'h0301, 32'h21, 32'h8000_0021, 0, 0));
        m_err.push_back(1'b0); m_dat.push_back(pack_rec(1'b0, 16'h0302, 32'h21, 32'h8000_0021, 0, 0));
        for (int i = 0; i < 3; i++) do_pop();

        // unplug of a configured function (R10)
        @(negedge clk);
        unplug_i = 1'b1; hp_cfg_i = 1'b1; hp_fid_i = 32'h33; hp_fh_i = 32'h8000_0033;
        @(posedge clk); #1;
        unplug_i = 1'b0;
        chk("R10 unconfig pulse", unconfig_o, 1'b1);
        chk("R10 first unplug record notify", notify_o, 1'b1);
        @(posedge clk); #1;
        chk("R10 unconfig single cycle", unconfig_o, 1'b0);
        chk("R10 second unplug record notify", notify_o, 1'b1);
        m_err.push_back(1'b0); m_dat.push_back(pack_rec(1'b0, 16'h0303, 32'h33, 32'h8000_0033, 0, 0));
        m_err.push_back(1'b0); m_dat.push_back(pack_rec(1'b0, 16'h0304, 32'h33, 32'h8000_0033, 0, 0));
        for (int i = 0; i < 3; i++) do_pop();

        // unplug of an unconfigured function (R10)
        @(negedge clk);
        unplug_i = 1'b1; hp_cfg_i = 1'b0; hp_fid_i = 32'h44; hp_fh_i = 32'h8000_0044;
        @(posedge clk); #1;
        unplug_i = 1'b0;
        chk("R10 no unconfig when not configured", unconfig_o, 1'b0);
        chk("R10 single record notify", notify_o, 1'b1);
        @(posedge clk); #1;
        chk("R10 no second record", notify_o, 1'b0);
        m_err.push_back(1'b0); m_dat.push_back(pack_rec(1'b0, 16'h0304, 32'h44, 32'h8000_0044, 0, 0));
        for (int i = 0; i < 2; i++) do_pop();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule